// File: doc/BRIEF.md
# Transfer Descriptor and Scatter-List Builder

This block turns one transfer request (slot number, data direction, byte length) into the fields of a transfer request descriptor and a scatter list that covers the data buffer. The data buffer is cut into fixed chunks of 4096 bytes. When a start pulse is accepted, the descriptor fields appear on a parallel bus for one cycle, marked by `desc_valid`. The scatter entries then leave one per handshake on a valid/ready stream. Each entry carries a 64-bit data address, a size field coded as byte count minus one, and a last flag.

The block only computes values. It does no memory writes and no DMA, and it does not read the command packet. A host sequencer gives the base of the per-slot command areas and the base of the data buffer. It pulses `start` and then moves the descriptor words and the entries into memory. `busy` is high for the whole run of entries. `err` flags a request that is too long for the entry budget, and `done` marks the end of the run.

Top module: `sgl_builder`

## Requirements
- R1: A request of length L with 0 < L < 40960 produces exactly ceil(L/4096) entries, and `ent_last` is high only on the final one.
- R2: Every entry except the last has size field 4095. The last entry has size L - 4096*(N-1) - 1, where N is the entry count.
- R3: Entry i has data address `data_base` + i*4096 (64-bit addition).
- R4: A request with L >= 40960 (10 entries of 4096) is rejected. `err` is high for exactly the cycle after start, with no `desc_valid`, no entries and `busy` low.
- R5: The command descriptor address is `cmd_base` + slot*4096. The low 32 bits go on `desc_cmd_lo` and the high 32 bits on `desc_cmd_hi`. The slot number also goes on `desc_tag`.
- R6: `desc_rsp_ofs` is 256 and `desc_prdt_ofs` is 512. Both count 32-bit words (byte offsets 1024 and 2048 within the command area).
- R7: `desc_dw0` = bit 28 set, plus direction code in bits 26:25, plus bit 24 set (interrupt on completion). Direction codes are 0 = no data, 1 = host to device and 2 = device to host. `desc_dw2` = 0x0000000F, the "invalid" completion-status code.
- R8: When L is zero, the direction field is forced to 0 and `desc_prdt_len` is 0. No entry is emitted, and `done` is high in the cycle after start. For a non-zero length, `desc_prdt_len` equals the entry count.
- R9: `desc_valid` is high for exactly the cycle after an accepted start. `busy` is high from the cycle after start until the handshake of the last entry, and `done` is high in the cycle after that handshake. A start that arrives while `busy` is high is ignored.
- R10: While `ent_valid` is high and `ent_ready` is low, the entry outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| req_slot | input | 5 | Slot number |
| req_dir | input | 2 | Data direction code |
| req_len | input | 32 | Data length in bytes |
| cmd_base | input | 64 | Base address of the slot command areas |
| data_base | input | 64 | Base address of the data buffer |
| desc_valid | output | 1 | Descriptor fields valid (one cycle) |
| desc_dw0 | output | 32 | Header word 0 |
| desc_dw2 | output | 32 | Header word 2 |
| desc_cmd_lo | output | 32 | Command descriptor address, low half |
| desc_cmd_hi | output | 32 | Command descriptor address, high half |
| desc_rsp_ofs | output | 16 | Response packet offset in words |
| desc_prdt_ofs | output | 16 | Scatter table offset in words |
| desc_prdt_len | output | 16 | Scatter table entry count |
| desc_tag | output | 8 | Task tag (slot number) |
| ent_valid | output | 1 | Entry valid |
| ent_ready | input | 1 | Entry accepted by the consumer |
| ent_addr | output | 64 | Entry data address |
| ent_size | output | 32 | Entry byte count minus one |
| ent_last | output | 1 | Final entry of the list |
| busy | output | 1 | Entry run in progress |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request rejected as too long (one cycle) |

## Verification
The hardest cases are a start that lands while a run is still going and a last handshake that meets backpressure, because both depend on how the consumer's ready lines up with the request strobe. To reach them, the stimulus issues a second request one cycle after a long one has been accepted. It also switches the ready pattern to one that stalls every third cycle. The length sweep covers the corners of the chunk arithmetic: zero, one byte, an exact chunk, a chunk plus one, the largest legal length, and the first rejected length.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  localparam logic [1:0] DIR_NONE = 2'd0;
  localparam logic [1:0] DIR_H2D  = 2'd1;
  localparam logic [1:0] DIR_D2H  = 2'd2;
  localparam int TYPE_BIT  = 28;
  localparam int DIR_LSB   = 25;
  localparam int IRQ_BIT   = 24;
  localparam logic [31:0] OCS_INVALID = 32'h0000_000F;
endpackage

// File: rtl/sgl_len_calc.sv
module sgl_len_calc #(
  parameter int LEN_W      = 32,
  parameter int CHUNK_LOG2 = 12,
  parameter int MAX_ENT    = 10,
  localparam int CNT_W     = $clog2(MAX_ENT + 1)
) (
  input  logic [LEN_W-1:0]      len,
  output logic [CNT_W-1:0]      cnt,
  output logic [CHUNK_LOG2-1:0] last_size,
  output logic                  oversize,
  output logic                  zero
);
  localparam logic [LEN_W:0] LIMIT = (LEN_W+1)'(MAX_ENT) << CHUNK_LOG2;

  always_comb begin
    zero      = (len == '0);
    oversize  = ({1'b0, len} >= LIMIT);
    cnt       = CNT_W'(len >> CHUNK_LOG2) + CNT_W'(|len[CHUNK_LOG2-1:0]);
    last_size = len[CHUNK_LOG2-1:0] - CHUNK_LOG2'(1);
  end
endmodule

// File: rtl/sgl_desc_fmt.sv
module sgl_desc_fmt
  import sgl_pkg::*;
#(
  parameter int SLOT_W        = 5,
  parameter int ADDR_W        = 64,
  parameter int CNT_W         = 4,
  parameter int AREA_LOG2     = 12,
  parameter int RSP_BYTE_OFS  = 1024,
  parameter int PRDT_BYTE_OFS = 2048
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        dir,
  input  logic              zero,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [CNT_W-1:0]  cnt,
  output logic [31:0]       dw0,
  output logic [31:0]       dw2,
  output logic [31:0]       cmd_lo,
  output logic [ADDR_W-33:0] cmd_hi,
  output logic [15:0]       rsp_ofs,
  output logic [15:0]       prdt_ofs,
  output logic [15:0]       prdt_len,
  output logic [7:0]        tag
);
  logic [ADDR_W-1:0] cmd_addr;
  logic [1:0]        dir_eff;

  always_comb begin
    dir_eff  = zero ? DIR_NONE : dir;
    cmd_addr = cmd_base + (ADDR_W'(slot) << AREA_LOG2);
    dw0      = (32'd1 << TYPE_BIT) | (32'(dir_eff) << DIR_LSB) | (32'd1 << IRQ_BIT);
    dw2      = OCS_INVALID;
    cmd_lo   = cmd_addr[31:0];
    cmd_hi   = cmd_addr[ADDR_W-1:32];
    rsp_ofs  = 16'(RSP_BYTE_OFS / 4);
    prdt_ofs = 16'(PRDT_BYTE_OFS / 4);
    prdt_len = zero ? 16'd0 : 16'(cnt);
    tag      = 8'(slot);
  end
endmodule

// File: rtl/sgl_entry_seq.sv
module sgl_entry_seq #(
  parameter int ADDR_W     = 64,
  parameter int SIZE_W     = 32,
  parameter int CHUNK_LOG2 = 12,
  parameter int MAX_ENT    = 10,
  localparam int CNT_W     = $clog2(MAX_ENT + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [CHUNK_LOG2-1:0] last_size,
  input  logic [ADDR_W-1:0]     data_base,
  input  logic                  ready,
  output logic                  valid,
  output logic [ADDR_W-1:0]     addr,
  output logic [SIZE_W-1:0]     size,
  output logic                  last,
  output logic                  fin
);
  localparam logic [CHUNK_LOG2-1:0] FULL = '1;
  localparam logic [ADDR_W-1:0]     STEP = ADDR_W'(1) << CHUNK_LOG2;

  logic [CNT_W-1:0]      rem;
  logic [CHUNK_LOG2-1:0] lsz;
  logic [CHUNK_LOG2-1:0] sz;
  logic                  xfer;

  assign xfer = valid && ready;
  assign fin  = xfer && last;
  assign size = SIZE_W'(sz);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      sz    <= '0;
      last  <= 1'b0;
      rem   <= '0;
      lsz   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= data_base;
      rem   <= cnt - CNT_W'(1);
      lsz   <= last_size;
      last  <= (cnt == CNT_W'(1));
      sz    <= (cnt == CNT_W'(1)) ? last_size : FULL;
    end else if (xfer) begin
      if (last) begin
        valid <= 1'b0;
        last  <= 1'b0;
      end else begin
        addr <= addr + STEP;
        rem  <= rem - CNT_W'(1);
        last <= (rem == CNT_W'(1));
        sz   <= (rem == CNT_W'(1)) ? lsz : FULL;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    valid && !ready && !load |=> valid && $stable(addr) && $stable(size) && $stable(last));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    xfer && !last && !load |=> valid && (addr == $past(addr) + STEP));

  assert_budget_R1: assert property (@(posedge clk) disable iff (rst)
    valid |-> (rem < CNT_W'(MAX_ENT)));

  assert_fullsize_R2: assert property (@(posedge clk) disable iff (rst)
    valid && !last |-> (size == SIZE_W'(FULL)));
endmodule

// File: rtl/sgl_builder.sv
module sgl_builder #(
  parameter int SLOT_W        = 5,
  parameter int LEN_W         = 32,
  parameter int ADDR_W        = 64,
  parameter int SIZE_W        = 32,
  parameter int CHUNK_LOG2    = 12,
  parameter int MAX_ENT       = 10,
  parameter int AREA_LOG2     = 12,
  parameter int RSP_BYTE_OFS  = 1024,
  parameter int PRDT_BYTE_OFS = 2048
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SLOT_W-1:0]  req_slot,
  input  logic [1:0]         req_dir,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [ADDR_W-1:0]  cmd_base,
  input  logic [ADDR_W-1:0]  data_base,
  output logic               desc_valid,
  output logic [31:0]        desc_dw0,
  output logic [31:0]        desc_dw2,
  output logic [31:0]        desc_cmd_lo,
  output logic [ADDR_W-33:0] desc_cmd_hi,
  output logic [15:0]        desc_rsp_ofs,
  output logic [15:0]        desc_prdt_ofs,
  output logic [15:0]        desc_prdt_len,
  output logic [7:0]         desc_tag,
  output logic               ent_valid,
  input  logic               ent_ready,
  output logic [ADDR_W-1:0]  ent_addr,
  output logic [SIZE_W-1:0]  ent_size,
  output logic               ent_last,
  output logic               busy,
  output logic               done,
  output logic               err
);
  localparam int CNT_W = $clog2(MAX_ENT + 1);

  logic [CNT_W-1:0]      cnt;
  logic [CHUNK_LOG2-1:0] last_size;
  logic                  oversize, zero, accept, load, fin;
  logic [31:0]           f_dw0, f_dw2, f_lo;
  logic [ADDR_W-33:0]    f_hi;
  logic [15:0]           f_rsp, f_prdt, f_len;
  logic [7:0]            f_tag;

  assign accept = start && !busy;
  assign load   = accept && !oversize && !zero;

  sgl_len_calc #(.LEN_W(LEN_W), .CHUNK_LOG2(CHUNK_LOG2), .MAX_ENT(MAX_ENT)) u_len (
    .len(req_len), .cnt(cnt), .last_size(last_size), .oversize(oversize), .zero(zero));

  sgl_desc_fmt #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .AREA_LOG2(AREA_LOG2),
                 .RSP_BYTE_OFS(RSP_BYTE_OFS), .PRDT_BYTE_OFS(PRDT_BYTE_OFS)) u_fmt (
    .slot(req_slot), .dir(req_dir), .zero(zero), .cmd_base(cmd_base), .cnt(cnt),
    .dw0(f_dw0), .dw2(f_dw2), .cmd_lo(f_lo), .cmd_hi(f_hi), .rsp_ofs(f_rsp),
    .prdt_ofs(f_prdt), .prdt_len(f_len), .tag(f_tag));

  sgl_entry_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CHUNK_LOG2(CHUNK_LOG2),
                  .MAX_ENT(MAX_ENT)) u_seq (
    .clk(clk), .rst(rst), .load(load), .cnt(cnt), .last_size(last_size),
    .data_base(data_base), .ready(ent_ready), .valid(ent_valid), .addr(ent_addr),
    .size(ent_size), .last(ent_last), .fin(fin));

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_valid    <= 1'b0;
      desc_dw0      <= '0;
      desc_dw2      <= '0;
      desc_cmd_lo   <= '0;
      desc_cmd_hi   <= '0;
      desc_rsp_ofs  <= '0;
      desc_prdt_ofs <= '0;
      desc_prdt_len <= '0;
      desc_tag      <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
      err           <= 1'b0;
    end else begin
      desc_valid <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      if (accept) begin
        if (oversize) begin
          err <= 1'b1;
        end else begin
          desc_valid    <= 1'b1;
          desc_dw0      <= f_dw0;
          desc_dw2      <= f_dw2;
          desc_cmd_lo   <= f_lo;
          desc_cmd_hi   <= f_hi;
          desc_rsp_ofs  <= f_rsp;
          desc_prdt_ofs <= f_prdt;
          desc_prdt_len <= f_len;
          desc_tag      <= f_tag;
          if (zero) done <= 1'b1;
          else      busy <= 1'b1;
        end
      end
      if (fin) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_reject_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    err |-> !desc_valid && !busy && !ent_valid);

  assert_idle_stream_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ent_valid);

  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
    start && busy && !fin |=> !desc_valid && !err);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !ent_valid);
endmodule

// File: tb/tb_sgl_builder.sv
module tb_sgl_builder;
  localparam int CLK_PERIOD = 10;
  localparam int CHUNK = 4096;
  localparam int MAXE  = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  req_slot = '0;
  logic [1:0]  req_dir = '0;
  logic [31:0] req_len = '0;
  logic [63:0] cmd_base = '0;
  logic [63:0] data_base = '0;
  logic        desc_valid, ent_valid, ent_last, busy, done, err;
  logic        ent_ready = 1'b1;
  logic [31:0] desc_dw0, desc_dw2, desc_cmd_lo, desc_cmd_hi, ent_size;
  logic [15:0] desc_rsp_ofs, desc_prdt_ofs, desc_prdt_len;
  logic [7:0]  desc_tag;
  logic [63:0] ent_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgl_builder dut (
    .clk(clk), .rst(rst), .start(start), .req_slot(req_slot), .req_dir(req_dir),
    .req_len(req_len), .cmd_base(cmd_base), .data_base(data_base),
    .desc_valid(desc_valid), .desc_dw0(desc_dw0), .desc_dw2(desc_dw2),
    .desc_cmd_lo(desc_cmd_lo), .desc_cmd_hi(desc_cmd_hi), .desc_rsp_ofs(desc_rsp_ofs),
    .desc_prdt_ofs(desc_prdt_ofs), .desc_prdt_len(desc_prdt_len), .desc_tag(desc_tag),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr),
    .ent_size(ent_size), .ent_last(ent_last), .busy(busy), .done(done), .err(err));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ready_mode = 0;
  bit mon_on = 0;

  logic [63:0] q_addr[$];
  logic [31:0] q_size[$];
  logic        q_last[$];
  bit desc_due = 0, err_due = 0, done_due = 0;
  logic [31:0] e_dw0, e_lo, e_hi;
  logic [15:0] e_len;
  logic [7:0]  e_tag;
  bit hold_pend = 0;
  logic [63:0] h_addr;
  logic [31:0] h_size;
  logic        h_last;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 50000);
      report();
      $finish;
    end
  end

  // Behavioural reference, compared every cycle at the falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      ent_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      chk(busy === (q_addr.size() > 0), "R9 busy", 64'(busy), 64'(q_addr.size() > 0));
      chk(done === done_due, "R9 done", 64'(done), 64'(done_due));
      chk(desc_valid === desc_due, "R9 desc_valid", 64'(desc_valid), 64'(desc_due));
      chk(err === err_due, "R4 err", 64'(err), 64'(err_due));
      if (desc_due && desc_valid) begin
        chk(desc_dw0 === e_dw0, "R7 dw0", 64'(desc_dw0), 64'(e_dw0));
        chk(desc_dw2 === 32'hF, "R7 dw2", 64'(desc_dw2), 64'hF);
        chk(desc_cmd_lo === e_lo, "R5 cmd_lo", 64'(desc_cmd_lo), 64'(e_lo));
        chk(desc_cmd_hi === e_hi, "R5 cmd_hi", 64'(desc_cmd_hi), 64'(e_hi));
        chk(desc_tag === e_tag, "R5 tag", 64'(desc_tag), 64'(e_tag));
        chk(desc_rsp_ofs === 16'd256, "R6 rsp_ofs", 64'(desc_rsp_ofs), 64'd256);
        chk(desc_prdt_ofs === 16'd512, "R6 prdt_ofs", 64'(desc_prdt_ofs), 64'd512);
        chk(desc_prdt_len === e_len, "R8 prdt_len", 64'(desc_prdt_len), 64'(e_len));
      end
      if (hold_pend) begin
        chk(ent_valid === 1'b1 && ent_addr === h_addr && ent_size === h_size && ent_last === h_last,
            "R10 stall hold", ent_addr, h_addr);
      end
      hold_pend = 0;
      desc_due = 0;
      err_due = 0;
      done_due = 0;
      if (ent_valid && !ent_ready) begin
        hold_pend = 1; h_addr = ent_addr; h_size = ent_size; h_last = ent_last;
      end
      if (ent_valid && ent_ready) begin
        if (q_addr.size() == 0) begin
          chk(0, "R1 unexpected entry", ent_addr, 64'h0);
        end else begin
          logic [63:0] ea; logic [31:0] es; logic el;
          ea = q_addr.pop_front(); es = q_size.pop_front(); el = q_last.pop_front();
          chk(ent_addr === ea, "R3 entry addr", ent_addr, ea);
          chk(ent_size === es, "R2 entry size", 64'(ent_size), 64'(es));
          chk(ent_last === el, "R1 entry last", 64'(ent_last), 64'(el));
          if (el) done_due = 1;
        end
      end
    end
  end

  task automatic request(input logic [4:0] s, input logic [1:0] d, input logic [31:0] len,
                         input logic [63:0] cb, input logic [63:0] db);
    bit acc;
    @(posedge clk); #1;
    start = 1'b1; req_slot = s; req_dir = d; req_len = len; cmd_base = cb; data_base = db;
    @(negedge clk); #1;
    acc = (q_addr.size() == 0) && !done_due;
    @(posedge clk); #1;
    start = 1'b0;
    if (acc) begin
      if (len >= MAXE * CHUNK) begin
        err_due = 1;
      end else begin
        int n;
        logic [63:0] ca;
        n = (len + CHUNK - 1) / CHUNK;
        ca = cb + 64'(s) * CHUNK;
        desc_due = 1;
        e_lo = ca[31:0]; e_hi = ca[63:32]; e_tag = 8'(s); e_len = 16'(n);
        e_dw0 = 32'h1000_0000 | 32'h0100_0000 | (32'((len == 0) ? 2'd0 : d) << 25);
        if (n == 0) done_due = 1;
        for (int i = 0; i < n; i++) begin
          q_addr.push_back(db + 64'(i) * CHUNK);
          q_size.push_back((i == n - 1) ? (len - CHUNK * (n - 1) - 1) : 32'(CHUNK - 1));
          q_last.push_back(i == n - 1);
        end
      end
    end
  endtask

  task automatic wait_idle();
    while (q_addr.size() != 0 || done_due || desc_due || err_due) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!busy && !ent_valid && !desc_valid && !done && !err, "R9 reset state",
        {59'd0, busy, ent_valid, desc_valid, done, err}, 64'd0);
    mon_on = 1;
    // R8 zero length forces no-data direction
    request(5'd3, 2'd1, 32'd0, 64'h0000_0001_0000_0000, 64'h8000); wait_idle();
    // R1 R2 single byte, exact chunk, chunk plus one
    request(5'd0, 2'd2, 32'd1, 64'h2000_0000, 64'h10_0000); wait_idle();
    request(5'd31, 2'd1, 32'd4096, 64'hFFFF_FFFF_FFFF_0000, 64'h20_0000); wait_idle();
    request(5'd7, 2'd2, 32'd4097, 64'h0000_0002_FFFF_F000, 64'hFFFF_FFFF_FFFF_F000); wait_idle();
    // R1 largest legal length
    request(5'd9, 2'd1, 32'd40959, 64'h4000, 64'h1_0000_0000); wait_idle();
    // R4 rejects
    request(5'd1, 2'd1, 32'd40960, 64'h4000, 64'h0); wait_idle();
    request(5'd2, 2'd2, 32'd100000, 64'h4000, 64'h0); wait_idle();
    // R10 backpressure and R9 start ignored while busy
    ready_mode = 1;
    request(5'd4, 2'd2, 32'd20000, 64'h9000, 64'h30_0000);
    request(5'd5, 2'd1, 32'd8192, 64'hA000, 64'h40_0000);
    wait_idle();
    request(5'd6, 2'd1, 32'd12288, 64'h5000, 64'h50_0000); wait_idle();
    request(5'd8, 2'd2, 32'd4095, 64'h5000, 64'h60_0000); wait_idle();
    ready_mode = 0;
    request(5'd10, 2'd1, 32'd36864, 64'h1234_5000, 64'h70_0000);
    request(5'd11, 2'd2, 32'd50000, 64'h0, 64'h0);
    wait_idle();
    report();
    $finish;
  end
endmodule